// File: doc/BRIEF.md
# Bitmask Dictionary Code Decompressor

This block expands a packed stream of compressed code back into fixed-width code vectors. The packed stream arrives as fixed-width words on a valid/ready input. Inside the block, a bit aligner collects those words into one continuous MSB-first bit sequence. Each entry in the sequence takes one of three forms:

- a literal vector;
- a short reference to a dictionary word;
- a reference to a dictionary word plus a 2-bit XOR mask placed at an encoded bit position, which rebuilds vectors that almost match a stored word.

Each expanded vector leaves through a registered valid/ready output.

The dictionary must be loaded through a simple write port before decoding starts. When the fetch path jumps, it pulses the flush input. A flush throws away every buffered bit and every vector still in flight, and the next word accepted begins a fresh entry. This works because jump targets are aligned to word boundaries in the packed stream.

Top module: `bm_decomp`

## Requirements
- R1: A leading bit of 1 marks a literal entry. The next VEC_W bits, taken MSB first, are emitted unchanged as the vector, so the entry is 9 bits long at the default width.
- R2: The bit pair 0,1 followed by an IDX_W-bit index emits the dictionary word at that index. At the defaults this entry is 3 bits long.
- R3: The bit pair 0,0 starts a masked entry. The fields that follow are a 3-bit position, a 2-bit pattern and a 1-bit index, in that order. The emitted vector is the indexed word XORed with the pattern. The pattern's upper bit lands on bit `position`, counted from the MSB as 0, and its lower bit lands on the next bit toward the LSB. Any pattern bit that would fall past the LSB is dropped. Example: word 01000010 with pattern 11 at position 3 gives 01011010.
- R4: Input words are consumed MSB first as one continuous bit stream. Entries may straddle word boundaries and are decoded correctly when they do.
- R5: While the buffer holds a complete entry and the output is being accepted, the block emits one vector per clock.
- R6: A vector that is presented but not accepted keeps `out_vec` stable and `out_valid` high. Every encoded entry is emitted exactly once and in stream order.
- R7: While `flush` is high, `in_ready` is low. A flush also clears `out_valid` on the next cycle and discards the buffered bits and any partly decoded entry. The first vector after a flush comes from the first entry of the next word accepted.
- R8: A dictionary write with `dict_we` high updates the entry at `dict_addr`. Every later lookup of that index returns the new word.
- R9: After reset, `out_valid` is 0, `in_ready` is 1 and the bit buffer is empty.
- R10: `in_ready` drops while the buffer holds more than BUF_W−IN_W bits, where BUF_W = 2·IN_W. No word is lost or overwritten when the output is stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dict_we | input | 1 | Dictionary write strobe |
| dict_addr | input | IDX_W | Dictionary write index |
| dict_wdata | input | VEC_W | Dictionary write word |
| in_valid | input | 1 | Packed word present |
| in_word | input | IN_W | Packed stream word, first bit in the MSB |
| in_ready | output | 1 | Block accepts the packed word |
| flush | input | 1 | Discard buffered bits and pending vectors |
| out_valid | output | 1 | Expanded vector present |
| out_vec | output | VEC_W | Expanded code vector |
| out_ready | input | 1 | Consumer takes the vector |

## Verification
The bench aims at literal entries that straddle a word boundary. An aligner that joins words in the wrong place would emit rotated or shifted literals.

For masked entries, the bench uses position 0, the worked example at position 3, and position 7, where half the pattern falls off the LSB. A mask counted from the wrong end, or one that wraps around, shows up there as wrong bits.

The bench stalls the output while words keep arriving. A buffer without back-pressure would then overwrite bits and emit garbage. It also flushes in the middle of a literal with a vector still held at the output. A design that kept stale bits would then misalign every following entry, and one that kept the held vector would emit it after the flush.

A run of back-to-back dictionary hits exposes any bubble in the decode pipeline.

// File: rtl/bmd_pkg.sv
package bmd_pkg;
  typedef enum logic [1:0] {
    ENT_RAW    = 2'd0,
    ENT_HIT    = 2'd1,
    ENT_MASKED = 2'd2
  } ent_kind_e;
endpackage

// File: rtl/bmd_dict_ram.sv
module bmd_dict_ram #(
  parameter int W     = 8,
  parameter int DEPTH = 2,
  parameter int AW    = 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  // single write port plus registered read with enable: block RAM shape
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/bmd_bitbuf.sv
module bmd_bitbuf #(
  parameter int IN_W   = 16,
  parameter int HEAD_W = 9,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              in_valid,
  input  logic [IN_W-1:0]   in_word,
  output logic              in_ready,
  input  logic              take,
  input  logic [CNT_W-1:0]  take_len,
  output logic [HEAD_W-1:0] head,
  output logic [CNT_W-1:0]  cnt
);
  localparam int BUF_W = 2 * IN_W;
  localparam logic [CNT_W-1:0] ROOM = CNT_W'(BUF_W - IN_W);
  localparam logic [CNT_W-1:0] WORD = CNT_W'(IN_W);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BUF_W);

  logic [BUF_W-1:0] bits_q, bits_d;
  logic [CNT_W-1:0] cnt_d, rem;
  logic [CNT_W-1:0] used;
  logic [BUF_W-1:0] drained;

  assign in_ready = !flush && (cnt <= ROOM);
  assign head     = bits_q[BUF_W-1 -: HEAD_W];

  always_comb begin
    used    = take ? take_len : '0;
    rem     = cnt - used;
    drained = bits_q << used;
    bits_d  = drained;
    cnt_d   = rem;
    if (in_valid && in_ready) begin
      bits_d = drained | ({in_word, {IN_W{1'b0}}} >> rem);
      cnt_d  = rem + WORD;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      bits_q <= '0;
      cnt    <= '0;
    end else begin
      bits_q <= bits_d;
      cnt    <= cnt_d;
    end
  end

  p_cnt_bound_r10: assert property (@(posedge clk) disable iff (rst)
    cnt <= FULL);
  p_take_fit_r4: assert property (@(posedge clk) disable iff (rst)
    take |-> (take_len <= cnt));
  p_refill_r10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && !take) |=> (cnt == $past(cnt) + WORD));
endmodule

// File: rtl/bmd_entry_dec.sv
module bmd_entry_dec
  import bmd_pkg::*;
#(
  parameter int VEC_W  = 8,
  parameter int IDX_W  = 1,
  parameter int POS_W  = 3,
  parameter int HEAD_W = 9,
  parameter int CNT_W  = 6
) (
  input  logic [HEAD_W-1:0] head,
  input  logic [CNT_W-1:0]  cnt,
  output logic              ok,
  output logic [CNT_W-1:0]  len,
  output ent_kind_e         kind,
  output logic [IDX_W-1:0]  idx,
  output logic [POS_W-1:0]  pos,
  output logic [1:0]        pat,
  output logic [VEC_W-1:0]  raw
);
  localparam logic [CNT_W-1:0] LEN_RAW = CNT_W'(1 + VEC_W);
  localparam logic [CNT_W-1:0] LEN_HIT = CNT_W'(2 + IDX_W);
  localparam logic [CNT_W-1:0] LEN_MSK = CNT_W'(4 + POS_W + IDX_W);

  logic lit_flag, exact_flag;

  assign lit_flag   = head[HEAD_W-1];
  assign exact_flag = head[HEAD_W-2];
  assign raw        = head[HEAD_W-2 -: VEC_W];
  assign pos        = head[HEAD_W-3 -: POS_W];
  assign pat        = head[HEAD_W-3-POS_W -: 2];

  always_comb begin
    if (lit_flag) begin
      kind = ENT_RAW;
      len  = LEN_RAW;
      idx  = '0;
    end else if (exact_flag) begin
      kind = ENT_HIT;
      len  = LEN_HIT;
      idx  = head[HEAD_W-3 -: IDX_W];
    end else begin
      kind = ENT_MASKED;
      len  = LEN_MSK;
      idx  = head[HEAD_W-5-POS_W -: IDX_W];
    end
    // flags are only meaningful once the bits exist; unfilled bits read 0
    ok = (cnt != '0) && (cnt >= len);
  end
endmodule

// File: rtl/bm_decomp.sv
module bm_decomp
  import bmd_pkg::*;
#(
  parameter int VEC_W      = 8,
  parameter int DICT_DEPTH = 2,
  parameter int IN_W       = 16,
  localparam int IDX_W     = (DICT_DEPTH > 1) ? $clog2(DICT_DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dict_we,
  input  logic [IDX_W-1:0] dict_addr,
  input  logic [VEC_W-1:0] dict_wdata,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  in_word,
  output logic             in_ready,
  input  logic             flush,
  output logic             out_valid,
  output logic [VEC_W-1:0] out_vec,
  input  logic             out_ready
);
  localparam int POS_W   = $clog2(VEC_W);
  localparam int RAW_LEN = 1 + VEC_W;
  localparam int MSK_LEN = 4 + POS_W + IDX_W;
  localparam int HEAD_W  = (RAW_LEN > MSK_LEN) ? RAW_LEN : MSK_LEN;
  localparam int BUF_W   = 2 * IN_W;
  localparam int CNT_W   = $clog2(BUF_W + 1);

  logic [HEAD_W-1:0] head;
  logic [CNT_W-1:0]  cnt, dec_len;
  logic              dec_ok, take, s2_go;
  ent_kind_e         dec_kind;
  logic [IDX_W-1:0]  dec_idx;
  logic [POS_W-1:0]  dec_pos;
  logic [1:0]        dec_pat;
  logic [VEC_W-1:0]  dec_raw;
  logic [VEC_W+1:0]  mask_wide;
  logic [VEC_W-1:0]  dec_mask;
  logic [VEC_W-1:0]  dict_q;

  logic              s1_v;
  ent_kind_e         s1_kind;
  logic [VEC_W-1:0]  s1_raw, s1_mask;

  bmd_bitbuf #(.IN_W(IN_W), .HEAD_W(HEAD_W), .CNT_W(CNT_W)) u_buf (
    .clk(clk), .rst(rst), .flush(flush),
    .in_valid(in_valid), .in_word(in_word), .in_ready(in_ready),
    .take(take), .take_len(dec_len), .head(head), .cnt(cnt)
  );

  bmd_entry_dec #(.VEC_W(VEC_W), .IDX_W(IDX_W), .POS_W(POS_W),
                  .HEAD_W(HEAD_W), .CNT_W(CNT_W)) u_dec (
    .head(head), .cnt(cnt), .ok(dec_ok), .len(dec_len), .kind(dec_kind),
    .idx(dec_idx), .pos(dec_pos), .pat(dec_pat), .raw(dec_raw)
  );

  bmd_dict_ram #(.W(VEC_W), .DEPTH(DICT_DEPTH), .AW(IDX_W)) u_dict (
    .clk(clk), .we(dict_we), .waddr(dict_addr), .wdata(dict_wdata),
    .re(take), .raddr(dec_idx), .rdata(dict_q)
  );

  // positioned 2-bit mask, MSB-relative; bits pushed past the LSB fall away
  assign mask_wide = {dec_pat, {VEC_W{1'b0}}} >> dec_pos;
  assign dec_mask  = (dec_kind == ENT_MASKED) ? mask_wide[VEC_W+1:2] : '0;

  assign s2_go = s1_v && (!out_valid || out_ready);
  assign take  = !flush && dec_ok && (!s1_v || s2_go);

  // stage 1: fields registered alongside the dictionary read
  always_ff @(posedge clk) begin
    if (rst || flush) begin
      s1_v <= 1'b0;
    end else if (take) begin
      s1_v <= 1'b1;
    end else if (s2_go) begin
      s1_v <= 1'b0;
    end
    if (take) begin
      s1_kind <= dec_kind;
      s1_raw  <= dec_raw;
      s1_mask <= dec_mask;
    end
  end

  // stage 2: registered output
  always_ff @(posedge clk) begin
    if (rst || flush) begin
      out_valid <= 1'b0;
      out_vec   <= '0;
    end else if (s2_go) begin
      out_valid <= 1'b1;
      out_vec   <= (s1_kind == ENT_RAW) ? s1_raw : (dict_q ^ s1_mask);
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready && !flush) |=> (out_valid && $stable(out_vec)));
  p_flush_drop_r7: assert property (@(posedge clk) disable iff (rst)
    flush |=> (!out_valid && !s1_v && (cnt == '0)));
  p_no_take_flush_r7: assert property (@(posedge clk) disable iff (rst)
    flush |-> (!take && !in_ready));
  p_stage_advance_r5: assert property (@(posedge clk) disable iff (rst)
    (s1_v && out_ready && !flush) |=> out_valid);
endmodule

// File: tb/sim_bm_decomp.sv
module sim_bm_decomp;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic       dict_we = 1'b0;
  logic       dict_addr = 1'b0;
  logic [7:0] dict_wdata = '0;
  logic       in_valid = 1'b0;
  logic [15:0] in_word = '0;
  logic       in_ready;
  logic       flush = 1'b0;
  logic       out_valid;
  logic [7:0] out_vec;
  logic       out_ready = 1'b0;

  bm_decomp #(.VEC_W(8), .DICT_DEPTH(2), .IN_W(16)) u0 (
    .clk(clk), .rst(rst), .dict_we(dict_we), .dict_addr(dict_addr),
    .dict_wdata(dict_wdata), .in_valid(in_valid), .in_word(in_word),
    .in_ready(in_ready), .flush(flush), .out_valid(out_valid),
    .out_vec(out_vec), .out_ready(out_ready)
  );

  int     n_chk = 0;
  int     n_bad = 0;
  longint cyc = 0;
  int     rdy_mode = 2;
  string  cur_req = "R9";
  logic   bq[$];
  logic [7:0] exq[$];
  longint stamps[$];
  logic [7:0] dict_m [2];

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    #2;
    case (rdy_mode)
      0:       out_ready = 1'b1;
      1:       out_ready = (cyc % 3 != 1);
      default: out_ready = 1'b0;
    endcase
  end

  task automatic check(input bit cond, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!cond) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, expv);
    end
  endtask

  // output monitor: transfer happens at the coming edge
  always @(negedge clk) begin
    logic [7:0] e;
    if (!rst && out_valid && out_ready) begin
      n_chk++;
      stamps.push_back(cyc);
      if (exq.size() == 0) begin
        n_bad++;
        $display("FAIL %s unexpected vector act=%h exp=none", cur_req, out_vec);
      end else begin
        e = exq.pop_front();
        if (out_vec !== e) begin
          n_bad++;
          $display("FAIL %s vector act=%h exp=%h", cur_req, out_vec, e);
        end
      end
    end
  end

  task automatic put_bits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) bq.push_back(v[i]);
  endtask

  task automatic push_raw(input logic [7:0] v);
    put_bits(32'd1, 1);
    put_bits({24'd0, v}, 8);
    exq.push_back(v);
  endtask

  task automatic push_hit(input int i);
    put_bits(32'b01, 2);
    put_bits(i, 1);
    exq.push_back(dict_m[i]);
  endtask

  task automatic push_mask(input int p, input int pt, input int i);
    int m;
    put_bits(32'b00, 2);
    put_bits(p, 3);
    put_bits(pt, 2);
    put_bits(i, 1);
    m = (((pt << 8) >> p) >> 2) & 8'hFF;
    exq.push_back(dict_m[i] ^ m[7:0]);
  endtask

  task automatic send_words();
    logic [15:0] w;
    @(negedge clk);
    while (bq.size() >= 16) begin
      for (int i = 0; i < 16; i++) w[15-i] = bq.pop_front();
      in_valid = 1'b1;
      in_word  = w;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  task automatic send_all();
    while ((bq.size() % 16) != 0 && (16 - (bq.size() % 16)) >= 9)
      push_mask(0, 0, 0);
    while ((bq.size() % 16) != 0) bq.push_back(1'b0);
    send_words();
  endtask

  task automatic wait_drain(input string req);
    int t = 0;
    while (exq.size() != 0 && t < 400) begin
      @(negedge clk);
      t++;
    end
    check(exq.size() == 0, req, "drain pending", exq.size(), 0);
    repeat (6) @(negedge clk);
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    exq.delete();
    bq.delete();
  endtask

  task automatic dict_write(input int a, input logic [7:0] d);
    @(negedge clk);
    dict_we = 1'b1;
    dict_addr = a[0];
    dict_wdata = d;
    dict_m[a] = d;
    @(negedge clk);
    dict_we = 1'b0;
  endtask

  task automatic t_reset();
    cur_req = "R9";
    check(out_valid == 1'b0, "R9", "out_valid after reset", out_valid, 0);
    check(in_ready == 1'b1, "R9", "in_ready after reset", in_ready, 1);
  endtask

  task automatic t_raw_straddle();
    cur_req = "R1/R4";
    rdy_mode = 0;
    do_flush();
    push_raw(8'hA5); push_raw(8'h3C); push_raw(8'hFF);
    push_raw(8'h00); push_raw(8'h81); push_raw(8'h7E);
    send_all();
    wait_drain("R4");
  endtask

  task automatic t_hits();
    cur_req = "R2";
    rdy_mode = 0;
    do_flush();
    push_hit(1); push_hit(0); push_hit(1); push_raw(8'h5A); push_hit(0);
    send_all();
    wait_drain("R2");
  endtask

  task automatic t_masks();
    cur_req = "R3";
    rdy_mode = 0;
    do_flush();
    push_mask(3, 3, 1);   // worked example -> 01011010
    push_mask(0, 2, 0);   // top bit only
    push_mask(7, 3, 1);   // lower pattern bit drops past LSB
    push_mask(4, 1, 1);
    push_hit(1);
    send_all();
    wait_drain("R3");
  endtask

  task automatic t_rate();
    cur_req = "R5";
    rdy_mode = 0;
    do_flush();
    stamps.delete();
    push_hit(0); push_hit(1); push_hit(0); push_hit(1); push_hit(0);
    send_all();
    wait_drain("R5");
    check(stamps.size() == 5, "R5", "vector count", stamps.size(), 5);
    for (int i = 1; i < stamps.size(); i++)
      check(stamps[i] - stamps[i-1] == 1, "R5", "gap between vectors",
            32'(stamps[i] - stamps[i-1]), 1);
  endtask

  task automatic t_backpressure();
    cur_req = "R6";
    rdy_mode = 1;
    do_flush();
    push_raw(8'h11); push_mask(2, 1, 0); push_hit(1); push_raw(8'hEE);
    push_mask(6, 2, 1); push_hit(0); push_raw(8'h42); push_hit(1);
    send_all();
    wait_drain("R6");
  endtask

  task automatic t_fill_stall();
    cur_req = "R10";
    rdy_mode = 2;
    do_flush();
    for (int i = 0; i < 10; i++) push_raw(8'(8'h10 + i * 8'h13));
    fork
      send_all();
    join_none
    repeat (30) @(negedge clk);
    check(in_ready == 1'b0, "R10", "in_ready while buffer full", in_ready, 0);
    check(in_valid == 1'b1, "R10", "source still waiting", in_valid, 1);
    rdy_mode = 0;
    wait fork;
    wait_drain("R10");
  endtask

  task automatic t_flush();
    cur_req = "R7";
    rdy_mode = 2;
    do_flush();
    push_hit(0);
    push_raw(8'hA5);
    put_bits(32'hD, 4);     // first half of a literal that never completes
    send_words();
    repeat (8) @(negedge clk);
    check(out_valid == 1'b1, "R6", "held vector valid", out_valid, 1);
    check(out_vec == dict_m[0], "R6", "held vector value", out_vec, dict_m[0]);
    flush = 1'b1;
    #1;
    check(in_ready == 1'b0, "R7", "in_ready during flush", in_ready, 0);
    @(negedge clk);
    flush = 1'b0;
    exq.delete();
    bq.delete();
    check(out_valid == 1'b0, "R7", "out_valid after flush", out_valid, 0);
    rdy_mode = 0;
    push_raw(8'h3C);
    push_hit(1);
    send_all();
    wait_drain("R7");
  endtask

  task automatic t_dict_rewrite();
    cur_req = "R8";
    rdy_mode = 0;
    do_flush();
    dict_write(1, 8'h77);
    push_hit(1);
    push_mask(1, 1, 1);
    send_all();
    wait_drain("R8");
    dict_write(1, 8'h42);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired act=%0d exp=done", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    dict_m[0] = 8'h00;
    dict_m[1] = 8'h42;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    dict_write(0, 8'h00);
    dict_write(1, 8'h42);
    t_raw_straddle();
    t_hits();
    t_masks();
    t_rate();
    t_backpressure();
    t_fill_stall();
    t_flush();
    t_dict_rewrite();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule